// File: doc/BRIEF.md
# Instruction-Memory Store Lock Gate

This block sits on the bus path from the processor's load/store unit to a local memory. Any store whose address falls inside a configurable instruction-memory window passes through to the memory until software sets a lock bit. From then on, every such store is dropped before it reaches the memory. The gate answers the dropped store with a two-cycle bus error, raises a one-cycle non-maskable interrupt and counts the event. Reads, and stores outside the window, are forwarded unchanged whatever the lock state.

Software has a small register port with three registers: the lock, an interrupt vector that is presented to the core along with the interrupt, and a read-only count of blocked stores. The lock can only be set by software; only a core reset request clears it. The counter saturates and does not wrap. Typical use: firmware copies code into instruction memory, sets the lock, and from then on any stray store into the code region traps instead of corrupting it.

Top module: `imem_wlock_gate`

## Requirements
- R1: Writing register offset 0 with bit 0 equal to 1 sets the lock; a read of offset 0 then returns 1 in bit 0. The lock is 0 after reset.
- R2: Writing offset 0 with bit 0 equal to 0 has no effect on a set lock.
- R3: With the lock clear, a store inside the window is forwarded (`mem_req` high) and completes with the memory's ready, with no error and no interrupt.
- R4: With the lock set, a store inside the window never asserts `mem_req`, so the memory contents are unchanged.
- R5: A blocked store gets no response in the cycle it is presented. In the next cycle it gets `bus_err`=1 with `bus_ready`=0, and in the cycle after that `bus_err`=1 with `bus_ready`=1.
- R6: Each blocked store raises `nmi` for exactly one cycle, the first error cycle. `nmi_vec` always equals register offset 1, which software can write and which resets to `NMI_VEC_RST`.
- R7: Reads inside the window are forwarded with the memory's data and no error while the lock is set.
- R8: Stores and reads outside the window are forwarded with no error while the lock is set.
- R9: A one-cycle `core_rst_req` clears the lock, after which stores inside the window are forwarded again. The blocked-store count and the vector are kept.
- R10: Register offset 2 (read-only) holds the number of blocked stores, zero-extended. It counts up by one per blocked store and is visible from the first error cycle.
- R11: The count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| core_rst_req | input | 1 | Core reset request; clears the lock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| bus_req | input | 1 | Transfer request, held until bus_ready |
| bus_write | input | 1 | 1 = store, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Store data |
| bus_ready | output | 1 | Transfer completes in this cycle |
| bus_err | output | 1 | Error response |
| bus_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Forwarded request |
| mem_write | output | 1 | Forwarded direction |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded store data |
| mem_ready | input | 1 | Memory completion |
| mem_rdata | input | DATA_W | Memory read data |
| nmi | output | 1 | Non-maskable interrupt pulse |
| nmi_vec | output | DATA_W | Interrupt vector value |

## Verification
The assertions assume a requester that keeps `bus_req`, `bus_write` and `bus_addr` steady from the cycle a transfer is presented until the cycle `bus_ready` is high. Otherwise the error sequence could start for one transfer and finish for another. They also assume that `mem_ready` responds only to requests that were forwarded. The bench drives every transfer through one task that holds the request fields until completion and drops them in the following cycle. Its memory model answers at once, and no register write or core reset is issued while a transfer is in flight.

// File: rtl/imem_wlock_pkg.sv
// Shared types and register offsets for the instruction-memory store lock gate.
package imem_wlock_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_ERR_WAIT = 2'd1,
        SEQ_ERR_DONE = 2'd2
    } seq_state_e;

    localparam int CFG_ADDR_W = 2;
    localparam logic [CFG_ADDR_W-1:0] CFG_LOCK = 2'd0;
    localparam logic [CFG_ADDR_W-1:0] CFG_VEC  = 2'd1;
    localparam logic [CFG_ADDR_W-1:0] CFG_CNT  = 2'd2;

endpackage

// File: rtl/imem_wlock_regs.sv
// Register file holding the sticky lock bit and the interrupt vector, plus the
// read mux over lock, vector and blocked-store count.
// Assumes CNT_W <= DATA_W. core_rst_req has priority over a lock-setting write.
module imem_wlock_regs
    import imem_wlock_pkg::*;
#(
    parameter int              DATA_W      = 32,
    parameter int              CNT_W       = 8,
    parameter logic [DATA_W-1:0] NMI_VEC_RST = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  core_rst_req,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [CNT_W-1:0]      cnt_val,
    output logic [DATA_W-1:0]     cfg_rdata,
    output logic                  lock,
    output logic [DATA_W-1:0]     nmi_vec
);

    logic              lock_q;
    logic [DATA_W-1:0] vec_q;

    // Lock: set only by a write of one, cleared only by resets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (core_rst_req)
            lock_q <= 1'b0;
        else if (cfg_we && cfg_addr == CFG_LOCK && cfg_wdata[0])
            lock_q <= 1'b1;
    end

    // Vector register: plain software-writable value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= NMI_VEC_RST;
        else if (cfg_we && cfg_addr == CFG_VEC)
            vec_q <= cfg_wdata;
    end

    // Read mux over the three registers.
    always_comb begin
        unique case (cfg_addr)
            CFG_LOCK: cfg_rdata = DATA_W'(lock_q);
            CFG_VEC:  cfg_rdata = vec_q;
            CFG_CNT:  cfg_rdata = DATA_W'(cnt_val);
            default:  cfg_rdata = '0;
        endcase
    end

    assign lock    = lock_q;
    assign nmi_vec = vec_q;

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q && !core_rst_req |=> lock_q);
    assert_core_rst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |=> !lock_q);

endmodule

// File: rtl/imem_wlock_satcnt.sv
// Saturating event counter for blocked stores.
// Assumes inc is a single-cycle strobe per event.
module imem_wlock_satcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count events, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
    assert_cnt_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inc && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/imem_wlock_errseq.sv
// Error response sequencer: after a blocked store is seen in idle, it drives a
// wait-phase error (ready low), then a done-phase error (ready high), and emits
// a one-cycle interrupt pulse together with the wait phase.
// Assumes the requester holds its request until the done phase.
module imem_wlock_errseq
    import imem_wlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_store,
    output logic accept,
    output logic busy,
    output logic err,
    output logic err_ready,
    output logic nmi
);

    seq_state_e state_q, state_d;
    logic       nmi_q;

    assign accept = (state_q == SEQ_IDLE) && blk_store;

    // Next-state logic for the two-phase error response.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:     if (blk_store) state_d = SEQ_ERR_WAIT;
            SEQ_ERR_WAIT: state_d = SEQ_ERR_DONE;
            SEQ_ERR_DONE: state_d = SEQ_IDLE;
            default:      state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Interrupt pulse register, set once per accepted blocked store.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= accept;
    end

    assign busy      = state_q != SEQ_IDLE;
    assign err       = busy;
    assign err_ready = state_q == SEQ_ERR_DONE;
    assign nmi       = nmi_q;

    assert_err_two_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err && !err_ready |=> err && err_ready);
    assert_err_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err && err_ready |=> !err);
    assert_nmi_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);
    assert_nmi_with_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> err && !err_ready);

endmodule

// File: rtl/imem_wlock_gate.sv
// Top of the instruction-memory store lock gate. Decodes the instruction
// memory window, forwards every allowed transfer combinationally to the memory
// port, and hands blocked stores to the error sequencer.
// Assumes the window is aligned to 2**IMEM_SPAN_LOG2 bytes and that requests
// are held stable until bus_ready.
module imem_wlock_gate
    import imem_wlock_pkg::*;
#(
    parameter int                ADDR_W         = 32,
    parameter int                DATA_W         = 32,
    parameter int                CNT_W          = 8,
    parameter logic [ADDR_W-1:0] IMEM_BASE      = 32'h4000_0000,
    parameter int                IMEM_SPAN_LOG2 = 16,
    parameter logic [DATA_W-1:0] NMI_VEC_RST    = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  core_rst_req,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    input  logic                  bus_req,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_ready,
    output logic                  bus_err,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  mem_req,
    output logic                  mem_write,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_ready,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  nmi,
    output logic [DATA_W-1:0]     nmi_vec
);

    localparam int TAG_W = ADDR_W - IMEM_SPAN_LOG2;
    localparam logic [TAG_W-1:0] IMEM_TAG = IMEM_BASE[ADDR_W-1:IMEM_SPAN_LOG2];

    logic             lock;
    logic             imem_hit;
    logic             blk_store;
    logic             accept;
    logic             busy;
    logic             seq_err;
    logic             seq_ready;
    logic [CNT_W-1:0] cnt_val;

    // Window decode and blocking decision.
    always_comb begin
        imem_hit  = bus_addr[ADDR_W-1:IMEM_SPAN_LOG2] == IMEM_TAG;
        blk_store = bus_req && bus_write && imem_hit && lock;
    end

    // Forward path toward the memory and response mux toward the requester.
    always_comb begin
        mem_req   = bus_req && !blk_store && !busy;
        mem_write = bus_write;
        mem_addr  = bus_addr;
        mem_wdata = bus_wdata;
        bus_rdata = mem_rdata;
        bus_err   = seq_err;
        if (busy)           bus_ready = seq_ready;
        else if (blk_store) bus_ready = 1'b0;
        else                bus_ready = mem_ready;
    end

    imem_wlock_regs #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .NMI_VEC_RST (NMI_VEC_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_rst_req (core_rst_req),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cnt_val      (cnt_val),
        .cfg_rdata    (cfg_rdata),
        .lock         (lock),
        .nmi_vec      (nmi_vec)
    );

    imem_wlock_errseq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_store (blk_store),
        .accept    (accept),
        .busy      (busy),
        .err       (seq_err),
        .err_ready (seq_ready),
        .nmi       (nmi)
    );

    imem_wlock_satcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept),
        .cnt   (cnt_val)
    );

    assert_no_fwd_in_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> !mem_req);
    assert_locked_store_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock && bus_req && bus_write && imem_hit |-> !mem_req);
    assert_read_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_write && !seq_err |-> !bus_ready || mem_ready);
    assert_outside_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !imem_hit && !seq_err |-> mem_req);

endmodule

// File: tb/tb_imem_wlock_gate.sv
module tb_imem_wlock_gate;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam logic [DW-1:0] VEC0 = 32'h0000_0100;
    localparam logic [AW-1:0] IBASE = 32'h0001_0000;
    localparam logic [AW-1:0] DBASE = 32'h0002_0000;

    logic clk = 1'b0, rst_n = 1'b0, core_rst_req = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
    logic bus_req = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic bus_ready, bus_err;
    logic mem_req, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic nmi;
    logic [DW-1:0] nmi_vec;

    int checks = 0, errors = 0, exp_cnt = 0, wd = 0;
    logic [DW-1:0] mem [0:15];

    always #2 clk = ~clk;

    imem_wlock_gate #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .IMEM_BASE(IBASE),
                      .IMEM_SPAN_LOG2(12), .NMI_VEC_RST(VEC0)) dut (
        .clk(clk), .rst_n(rst_n), .core_rst_req(core_rst_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(1'b1), .mem_rdata(mem_rdata), .nmi(nmi), .nmi_vec(nmi_vec));

    // Memory model: always ready, index from address bit 17 and word bits.
    assign mem_rdata = mem[{mem_addr[17], mem_addr[4:2]}];
    always @(posedge clk) if (mem_req && mem_write) mem[{mem_addr[17], mem_addr[4:2]}] <= mem_wdata;

    // Watchdog.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
    endtask

    // One transfer: returns cycle count, per-cycle err/nmi bits, forward seen, read data.
    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int cyc, output logic [2:0] errv, output logic [2:0] nmiv,
                        output logic fwd, output logic [DW-1:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        cyc = 0; errv = '0; nmiv = '0; fwd = 1'b0; rd = '0;
        forever begin
            #1;
            if (cyc < 3) begin errv[cyc] = bus_err; nmiv[cyc] = nmi; end
            fwd = fwd | mem_req;
            rd = bus_rdata;
            cyc = cyc + 1;
            if (bus_ready || cyc > 8) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk); bus_req = 1'b0; bus_write = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 lock reset", {31'd0, dut.bus_err} | 32'd0, 32'd0);
        cfg_rd(2'd0, v); chk("R1 lock reset 0", v, 32'd0);
        cfg_rd(2'd2, v); chk("R10 count reset 0", v, 32'd0);
        chk("R6 vector reset", nmi_vec, VEC0);
        chk("R6 nmi low at reset", {31'd0, nmi}, 32'd0);
    endtask

    task automatic t_unlocked_store();
        int c; logic [2:0] e, n; logic f; logic [DW-1:0] r;
        xfer(1'b1, IBASE + 32'h4, 32'hA5A5_0001, c, e, n, f, r);
        chk("R3 one cycle", c, 1); chk("R3 no err", {29'd0, e}, 0);
        chk("R3 no nmi", {29'd0, n}, 0); chk("R3 forwarded", {31'd0, f}, 1);
        chk("R3 mem written", mem[1], 32'hA5A5_0001);
    endtask

    task automatic t_lock_set();
        logic [DW-1:0] v;
        cfg_wr(2'd0, 32'd1); cfg_rd(2'd0, v); chk("R1 lock set", v, 32'd1);
        cfg_wr(2'd0, 32'hFFFF_FFFE); cfg_rd(2'd0, v); chk("R2 zero write ignored", v, 32'd1);
    endtask

    task automatic t_blocked_store(input logic [AW-1:0] a, input int idx, input logic [DW-1:0] old);
        int c; logic [2:0] e, n; logic f; logic [DW-1:0] r, v;
        xfer(1'b1, a, 32'hDEAD_BEEF, c, e, n, f, r);
        exp_cnt = (exp_cnt < 15) ? exp_cnt + 1 : 15;
        chk("R5 three cycles", c, 3); chk("R5 err pattern", {29'd0, e}, 32'd6);
        chk("R6 nmi pulse", {29'd0, n}, 32'd2); chk("R4 not forwarded", {31'd0, f}, 0);
        chk("R4 mem unchanged", mem[idx], old);
        cfg_rd(2'd2, v); chk("R10 count", v, exp_cnt);
    endtask

    task automatic t_locked_passes();
        int c; logic [2:0] e, n; logic f; logic [DW-1:0] r;
        xfer(1'b0, IBASE + 32'h4, 0, c, e, n, f, r);
        chk("R7 read one cycle", c, 1); chk("R7 read no err", {29'd0, e}, 0);
        chk("R7 read data", r, 32'hA5A5_0001);
        xfer(1'b1, DBASE + 32'h8, 32'h1234_5678, c, e, n, f, r);
        chk("R8 outside store ok", {29'd0, e}, 0); chk("R8 outside written", mem[10], 32'h1234_5678);
        xfer(1'b0, DBASE + 32'h8, 0, c, e, n, f, r);
        chk("R8 outside read", r, 32'h1234_5678);
    endtask

    task automatic t_vector();
        cfg_wr(2'd1, 32'hCAFE_0040); chk("R6 vector written", nmi_vec, 32'hCAFE_0040);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 16; i++) t_blocked_store(IBASE + 32'h8, 2, mem[2]);
        chk("R11 saturated", exp_cnt, 15);
    endtask

    task automatic t_core_reset();
        int c; logic [2:0] e, n; logic f; logic [DW-1:0] r, v;
        @(negedge clk); core_rst_req = 1'b1; @(negedge clk); core_rst_req = 1'b0;
        cfg_rd(2'd0, v); chk("R9 lock cleared", v, 32'd0);
        cfg_rd(2'd2, v); chk("R9 count kept", v, 32'd15);
        chk("R9 vector kept", nmi_vec, 32'hCAFE_0040);
        xfer(1'b1, IBASE + 32'hC, 32'h0BAD_F00D, c, e, n, f, r);
        chk("R9 store passes", {29'd0, e}, 0); chk("R9 mem written", mem[3], 32'h0BAD_F00D);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h1111_0000 + i;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_unlocked_store();
        t_lock_set();
        t_blocked_store(IBASE + 32'h4, 1, 32'hA5A5_0001);
        t_blocked_store(IBASE + 32'h0, 0, 32'h1111_0000);
        t_locked_passes();
        t_vector();
        t_saturate();
        t_core_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule